// File: doc/BRIEF.md
# Watchdog Reset Counter

This block is a free-running timeout counter that resets the system when software stops servicing it. Every clock cycle it counts up. A write strobe to the service address, a fetch of the reset vector, or stop mode returns it to zero. If the count reaches the selected timeout, the block starts a two-phase reset. First it drives an active-low reset pin for a fixed number of cycles. Then it keeps the internal reset asserted for a second fixed window after the pin has been released.

Two configuration inputs are captured only at reset: one chooses the long or the short timeout, the other disables the watchdog. Captures happen in the first cycle after the power-on reset is released and in every cycle of the block's own reset stretch. Each trip also sets a sticky cause flag. The flag stays set until a status-register read strobe or a power-on reset clears it.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: With the long period captured, a trip happens exactly 2^LONG_EXP − 2^GUARD_EXP cycles after the last clock edge at which the counter was cleared; the pin is high one cycle earlier.
- R2: With the short period captured (period select = 1), the same spacing is 2^SHORT_EXP − 2^GUARD_EXP cycles.
- R3: A one-cycle service write strobe clears the counter, so servicing at intervals shorter than the timeout never causes a trip.
- R4: A trip drives the reset pin low for exactly PIN_CYC cycles, with the internal reset asserted throughout.
- R5: After the pin rises, the internal reset stays asserted for exactly HOLD_CYC further cycles, then drops, and counting restarts from zero.
- R6: A trip sets the cause flag, which stays set until a status read strobe or power-on reset clears it; a trip in the same cycle as a read leaves it set.
- R7: A reset-vector fetch strobe clears the counter in the same way as a service write.
- R8: While the stop input is high the counter is held at zero; counting restarts from zero when stop is released.
- R9: With the disable input captured as 1, no trip ever happens.
- R10: Changes on the disable and period-select inputs after capture have no effect until the next power-on reset or watchdog reset stretch.
- R11: During and just after power-on reset the pin is high, the internal reset is low and the cause flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_dis_i | input | 1 | Configuration: 1 disables watchdog resets |
| cfg_short_i | input | 1 | Configuration: 1 selects the short timeout |
| svc_wr_i | input | 1 | Write strobe to the service address |
| vec_fetch_i | input | 1 | Reset-vector fetch strobe |
| stop_i | input | 1 | Stop mode active; holds the counter clear |
| stat_rd_i | input | 1 | Read strobe of the reset status register |
| rst_pin_n_o | output | 1 | Active-low reset pin drive |
| rst_int_o | output | 1 | Internal system reset, active high |
| cause_o | output | 1 | Sticky watchdog reset cause flag |

## Verification
The timeout is measured from service writes, from the release of stop mode and from the end of a reset stretch. The pin is sampled one cycle before and exactly at the expected trip, so off-by-one errors in the terminal count or the clear path show up. A random sequence of service writes and vector fetches is applied at gaps up to one cycle short of the timeout, which separates a working clear from one that only slows the count. The configuration inputs are changed after capture and the old period is still expected, which separates capture-at-reset from live decoding. A disabled run is expected to stay quiet for well beyond the long period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_PIN  = 2'd1,
    PH_HOLD = 2'd2
  } wd_phase_e;
endpackage

// File: rtl/wdog_cfg_latch.sv
module wdog_cfg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic cfg_dis_i,
  input  logic cfg_short_i,
  output logic dis_o,
  output logic short_o
);
  logic armed_q;
  logic dis_q, dis_d;
  logic short_q, short_d;
  logic cap_en;

  // capture on the first cycle after power-on reset and during every stretch
  always_comb begin
    cap_en  = !armed_q || load_i;
    dis_d   = dis_q;
    short_d = short_q;
    if (cap_en) begin
      dis_d   = cfg_dis_i;
      short_d = cfg_short_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dis_q   <= 1'b1;
      short_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      dis_q   <= dis_d;
      short_q <= short_d;
    end
  end

  assign dis_o   = dis_q;
  assign short_o = short_q;
endmodule

// File: rtl/wdog_timeout_ctr.sv
module wdog_timeout_ctr #(
  parameter int LONG_EXP  = 18,
  parameter int SHORT_EXP = 13,
  parameter int GUARD_EXP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic short_i,
  output logic trip_o
);
  localparam int CW = LONG_EXP;
  localparam logic [CW-1:0] LONG_TERM  = CW'((1 << LONG_EXP)  - (1 << GUARD_EXP) - 1);
  localparam logic [CW-1:0] SHORT_TERM = CW'((1 << SHORT_EXP) - (1 << GUARD_EXP) - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] term;
  logic          at_term;

  assign term    = short_i ? SHORT_TERM : LONG_TERM;
  assign at_term = (cnt_q == term);
  assign trip_o  = run_i && !clr_i && at_term;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || trip_o) begin
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch
  import wdog_pkg::*;
#(
  parameter int PIN_CYC  = 32,
  parameter int HOLD_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  output logic pin_n_o,
  output logic int_o
);
  localparam int MAXC = (PIN_CYC > HOLD_CYC) ? PIN_CYC : HOLD_CYC;
  localparam int SW   = $clog2(MAXC + 1);
  localparam logic [SW-1:0] PIN_LAST  = SW'(PIN_CYC - 1);
  localparam logic [SW-1:0] HOLD_LAST = SW'(HOLD_CYC - 1);

  wd_phase_e     ph_q, ph_d;
  logic [SW-1:0] sc_q, sc_d;

  always_comb begin
    ph_d = ph_q;
    sc_d = sc_q;
    unique case (ph_q)
      PH_RUN: begin
        if (trip_i) begin
          ph_d = PH_PIN;
          sc_d = '0;
        end
      end
      PH_PIN: begin
        if (sc_q == PIN_LAST) begin
          ph_d = PH_HOLD;
          sc_d = '0;
        end else begin
          sc_d = sc_q + SW'(1);
        end
      end
      PH_HOLD: begin
        if (sc_q == HOLD_LAST) begin
          ph_d = PH_RUN;
          sc_d = '0;
        end else begin
          sc_d = sc_q + SW'(1);
        end
      end
      default: begin
        ph_d = PH_RUN;
        sc_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_RUN;
      sc_q <= '0;
    end else begin
      ph_q <= ph_d;
      sc_q <= sc_d;
    end
  end

  assign pin_n_o = (ph_q != PH_PIN);
  assign int_o   = (ph_q != PH_RUN);
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl #(
  parameter int LONG_EXP  = 18,
  parameter int SHORT_EXP = 13,
  parameter int GUARD_EXP = 4,
  parameter int PIN_CYC   = 32,
  parameter int HOLD_CYC  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_dis_i,
  input  logic cfg_short_i,
  input  logic svc_wr_i,
  input  logic vec_fetch_i,
  input  logic stop_i,
  input  logic stat_rd_i,
  output logic rst_pin_n_o,
  output logic rst_int_o,
  output logic cause_o
);
  logic dis_cap, short_cap;
  logic ctr_clr, ctr_run, trip;
  logic cause_q, cause_d;

  wdog_cfg_latch u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (rst_int_o),
    .cfg_dis_i   (cfg_dis_i),
    .cfg_short_i (cfg_short_i),
    .dis_o       (dis_cap),
    .short_o     (short_cap)
  );

  assign ctr_clr = svc_wr_i || vec_fetch_i || stop_i || rst_int_o;
  assign ctr_run = !dis_cap && !stop_i;

  wdog_timeout_ctr #(
    .LONG_EXP  (LONG_EXP),
    .SHORT_EXP (SHORT_EXP),
    .GUARD_EXP (GUARD_EXP)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (ctr_clr),
    .run_i   (ctr_run),
    .short_i (short_cap),
    .trip_o  (trip)
  );

  wdog_rst_stretch #(
    .PIN_CYC  (PIN_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_str (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip_i  (trip),
    .pin_n_o (rst_pin_n_o),
    .int_o   (rst_int_o)
  );

  // set has priority over the read-clear
  always_comb begin
    cause_d = cause_q;
    if (trip) begin
      cause_d = 1'b1;
    end else if (stat_rd_i) begin
      cause_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
    end else begin
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/wdog_rst_ctrl_chk.sv
module wdog_rst_ctrl_chk #(
  parameter int PIN_CYC  = 32,
  parameter int HOLD_CYC = 32
) (
  input logic clk,
  input logic rst_n,
  input logic svc_wr_i,
  input logic vec_fetch_i,
  input logic stop_i,
  input logic stat_rd_i,
  input logic rst_pin_n_o,
  input logic rst_int_o,
  input logic cause_o
);
  localparam int RW = $clog2(PIN_CYC + HOLD_CYC + 2);
  logic [RW-1:0] pin_run, int_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_run <= '0;
      int_run <= '0;
    end else begin
      pin_run <= !rst_pin_n_o ? pin_run + RW'(1) : '0;
      int_run <= rst_int_o ? int_run + RW'(1) : '0;
    end
  end

  // R4
  pin_in_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n_o |-> rst_int_o);

  // R4
  pin_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pin_n_o) |-> (pin_run == RW'(PIN_CYC)));

  // R5
  int_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_int_o) |-> (int_run == RW'(PIN_CYC + HOLD_CYC)));

  // R5
  hold_after_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pin_n_o) |-> rst_int_o);

  // R3
  svc_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr_i && !rst_int_o) |=> rst_pin_n_o);

  // R7
  vec_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch_i && !rst_int_o) |=> rst_pin_n_o);

  // R8
  stop_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !rst_int_o) |=> rst_pin_n_o);

  // R6
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_o) |-> $fell(rst_pin_n_o));

  // R6
  cause_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i |=> (!cause_o || $fell(rst_pin_n_o)));
endmodule

bind wdog_rst_ctrl wdog_rst_ctrl_chk #(
  .PIN_CYC  (PIN_CYC),
  .HOLD_CYC (HOLD_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .svc_wr_i    (svc_wr_i),
  .vec_fetch_i (vec_fetch_i),
  .stop_i      (stop_i),
  .stat_rd_i   (stat_rd_i),
  .rst_pin_n_o (rst_pin_n_o),
  .rst_int_o   (rst_int_o),
  .cause_o     (cause_o)
);

// File: tb/wdog_rst_ctrl_tb_top.sv
module wdog_rst_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_EXP   = 9;
  localparam int SHORT_EXP  = 7;
  localparam int GUARD_EXP  = 4;
  localparam int PIN_CYC    = 32;
  localparam int HOLD_CYC   = 32;

  logic clk = 1'b0;
  logic rst_n, cfg_dis, cfg_short, svc_wr, vec_fetch, stop_m, stat_rd;
  logic pin_n, rst_int, cause;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdog_rst_ctrl #(
    .LONG_EXP  (LONG_EXP),
    .SHORT_EXP (SHORT_EXP),
    .GUARD_EXP (GUARD_EXP),
    .PIN_CYC   (PIN_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dis_i   (cfg_dis),
    .cfg_short_i (cfg_short),
    .svc_wr_i    (svc_wr),
    .vec_fetch_i (vec_fetch),
    .stop_i      (stop_m),
    .stat_rd_i   (stat_rd),
    .rst_pin_n_o (pin_n),
    .rst_int_o   (rst_int),
    .cause_o     (cause)
  );

  function automatic int tmo(input bit short_sel);
    return short_sel ? (1 << SHORT_EXP) - (1 << GUARD_EXP)
                     : (1 << LONG_EXP) - (1 << GUARD_EXP);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_svc();
    svc_wr = 1'b1;
    step(1);
    svc_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0;
  endtask

  // checks pin one cycle before and at the trip, after the last clear edge
  task automatic expect_trip(input string req, input int t);
    step(t - 1);
    chk({req, " pin high before timeout"}, int'(pin_n), 1);
    step(1);
    chk({req, " pin low at timeout"}, int'(pin_n), 0);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h1a2b3c);
    rst_n = 1'b0; cfg_dis = 1'b0; cfg_short = 1'b0;
    svc_wr = 1'b0; vec_fetch = 1'b0; stop_m = 1'b0; stat_rd = 1'b0;
    step(3);
    // R11
    chk("R11 pin in reset", int'(pin_n), 1);
    chk("R11 int in reset", int'(rst_int), 0);
    chk("R11 cause in reset", int'(cause), 0);
    rst_n = 1'b1;
    step(2);
    chk("R11 pin after reset", int'(pin_n), 1);
    chk("R11 int after reset", int'(rst_int), 0);

    // R1 long period and R4/R5 stretch
    pulse_svc();
    expect_trip("R1", tmo(1'b0));
    chk("R6 cause set on trip", int'(cause), 1);
    chk("R4 int during pin", int'(rst_int), 1);
    step(PIN_CYC - 1);
    chk("R4 pin low last cycle", int'(pin_n), 0);
    step(1);
    chk("R4 pin released", int'(pin_n), 1);
    chk("R5 int after pin", int'(rst_int), 1);
    step(HOLD_CYC - 1);
    chk("R5 int last hold cycle", int'(rst_int), 1);
    step(1);
    chk("R5 int released", int'(rst_int), 0);
    chk("R6 cause sticky", int'(cause), 1);
    step(5);
    chk("R6 cause still sticky", int'(cause), 1);
    pulse_rd();
    chk("R6 cause cleared by read", int'(cause), 0);

    // R10: select change while running is ignored
    cfg_short = 1'b1;
    pulse_svc();
    expect_trip("R10", tmo(1'b0));
    step(PIN_CYC + HOLD_CYC);
    chk("R5 stretch over", int'(rst_int), 0);
    pulse_rd();

    // R2: short period now captured during the stretch
    pulse_svc();
    expect_trip("R2", tmo(1'b1));
    step(PIN_CYC + HOLD_CYC);
    pulse_rd();

    // R3 / R7: random service writes and vector fetches
    pulse_svc();
    for (int i = 0; i < 60; i++) begin
      int gap;
      gap = (i == 59) ? tmo(1'b1) - 1 : $urandom_range(tmo(1'b1) - 1, 1);
      step(gap - 1);
      if ($urandom_range(1, 0) == 1) begin
        vec_fetch = 1'b1;
        step(1);
        vec_fetch = 1'b0;
        chk("R7 no trip with vector fetch", int'(pin_n), 1);
      end else begin
        pulse_svc();
        chk("R3 no trip with service", int'(pin_n), 1);
      end
    end
    chk("R6 no cause while serviced", int'(cause), 0);

    // R7 directed: vector fetch restarts a full timeout
    vec_fetch = 1'b1;
    step(1);
    vec_fetch = 1'b0;
    expect_trip("R7", tmo(1'b1));
    step(PIN_CYC + HOLD_CYC);
    pulse_rd();

    // R8: stop holds the counter clear
    stop_m = 1'b1;
    step(3 * tmo(1'b1));
    chk("R8 no trip in stop", int'(pin_n), 1);
    stop_m = 1'b0;
    expect_trip("R8", tmo(1'b1));
    step(PIN_CYC + HOLD_CYC);

    // R6: power-on reset clears the sticky cause; R9 disabled
    chk("R6 cause before por", int'(cause), 1);
    cfg_dis = 1'b1;
    rst_n = 1'b0;
    step(2);
    chk("R6 cause cleared by por", int'(cause), 0);
    rst_n = 1'b1;
    step(2);
    cfg_dis = 1'b0;
    step(2 * tmo(1'b0));
    chk("R9 no trip when disabled", int'(pin_n), 1);
    chk("R10 enable change ignored", int'(rst_int), 0);
    chk("R9 no cause when disabled", int'(cause), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: bench did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule